// File: doc/BRIEF.md
# Configurable Logic Cell Column

This block is a vertical stack of identical logic cells of the kind found in a fine-grained programmable fabric. Every cell holds a four-input lookup table driven by its own 16-bit truth table, a carry unit that forms the majority of two of the table inputs and an incoming carry, and one storage flop that can capture the table result. The carry passes from each cell to the cell above it. The bottom cell takes its carry from a column input, and the top cell drives the column carry output.

The flop's behaviour is fixed at elaboration. Parameters set the capturing clock edge, say whether a clock enable is honoured, and choose whether the shared set/reset line clears the flops, presets them or does nothing. A further parameter makes that line act on the clock edge or at once. A per-cell select bit chooses whether the cell's output is the raw table result or the stored one. The configuration inputs (truth tables and select bits) are treated as static data supplied by the surrounding fabric.

Top module: `lcc_top`

## Requirements
- R1: For cell c, `lutOut[c]` equals bit `truthTab[16*c + n]`, where n is the 4-bit number `lutIn[4*c+3 : 4*c]`. Bit `lutIn[4*c]` is the least significant input I0.
- R2: The carry of cell c is 1 exactly when at least two of I0 (`lutIn[4*c]`), I1 (`lutIn[4*c+1]`) and that cell's incoming carry are 1.
- R3: Cell 0 takes its incoming carry from `carryIn`. Cell c>0 takes it from `carryChain[c-1]`. `carryOut` equals `carryChain[CELLS-1]`.
- R4: On each active clock edge (rising when ACTIVE_RISING=1, falling otherwise), `regOut[c]` loads `lutOut[c]` if the enable allows it.
- R5: With HAS_ENABLE=1, an active edge with `clkEn` low leaves `regOut` unchanged. With HAS_ENABLE=0, `clkEn` has no effect.
- R6: With a synchronous set/reset kind, `srIn` high at an active edge forces every `regOut` bit to 0 (reset kind) or 1 (set kind), whatever `clkEn` is. Before that edge `regOut` does not change.
- R7: With an asynchronous set/reset kind, `srIn` high forces `regOut` to its reset or set value at once, with no clock edge needed.
- R8: Every flop holds 0 before the first capturing edge.
- R9: `cellOut[c]` equals `regOut[c]` when `regSel[c]` is 1, and `lutOut[c]` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of all cell flops |
| clkEn | input | 1 | Shared clock enable, used only when HAS_ENABLE=1 |
| srIn | input | 1 | Shared set/reset line, active high |
| carryIn | input | 1 | Carry into the bottom cell |
| lutIn | input | 4*CELLS | Four table inputs per cell, I0 at the lowest bit |
| truthTab | input | 16*CELLS | 16-bit truth table per cell |
| regSel | input | CELLS | Per-cell output select: 1 = stored, 0 = direct |
| lutOut | output | CELLS | Direct table result per cell |
| regOut | output | CELLS | Stored table result per cell |
| cellOut | output | CELLS | Selected output per cell |
| carryChain | output | CELLS | Carry produced by each cell |
| carryOut | output | 1 | Carry out of the top cell |

## Verification
Two columns run side by side. One uses a rising edge, an enable and a synchronous reset. The other uses a falling edge, no enable and an asynchronous set, so the edge choice and both set/reset timings show up against the same table stimulus. Each input index is swept across tables with different shapes (single-minterm AND, parity, near-all-ones and an irregular mix), which separates a correct bit selection from a bit-reversed or offset one. A chain of propagate cells with the carry input toggling shows that the carry passes through all eight cells. Random phases mix the enable, the reset and the select bits, and check both that reset wins over a low enable and that a low enable holds the stored value.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    SR_NONE  = 2'd0,
    SR_RESET = 2'd1,
    SR_SET   = 2'd2
  } srKind_e;

  typedef struct packed {
    logic load;
    logic srActive;
    logic srFill;
  } cellStrobe_t;
endpackage

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
#(
  parameter bit      HAS_ENABLE = 1'b1,
  parameter srKind_e SR_KIND    = SR_RESET
) (
  input  logic        clkEn,
  input  logic        srIn,
  output cellStrobe_t strobe
);
  localparam bit SR_PRESENT = (SR_KIND != SR_NONE);
  localparam bit FILL_VALUE = (SR_KIND == SR_SET);

  always_comb begin
    strobe.load     = HAS_ENABLE ? clkEn : 1'b1;
    strobe.srActive = SR_PRESENT ? srIn : 1'b0;
    strobe.srFill   = FILL_VALUE;
  end
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
  import lcc_pkg::*;
#(
  parameter int LUT_K         = 4,
  parameter bit ACTIVE_RISING = 1'b1,
  parameter bit SR_ASYNC      = 1'b0,
  localparam int TABLE        = 1 << LUT_K
) (
  input  logic             clk,
  input  cellStrobe_t      strobe,
  input  logic [LUT_K-1:0] lutIn,
  input  logic [TABLE-1:0] truthTab,
  input  logic             carryIn,
  input  logic             regSel,
  output logic             lutOut,
  output logic             regOut,
  output logic             cellOut,
  output logic             carryOut
);
  logic stored = 1'b0;
  logic srHit;

  assign srHit    = strobe.srActive;
  assign lutOut   = truthTab[lutIn];
  assign carryOut = (lutIn[0] & lutIn[1]) | (lutIn[1] & carryIn) | (carryIn & lutIn[0]);

  generate
    if (ACTIVE_RISING && SR_ASYNC) begin : g_riseAsync
      always_ff @(posedge clk or posedge srHit)
        if (srHit)            stored <= strobe.srFill;
        else if (strobe.load) stored <= lutOut;
    end else if (ACTIVE_RISING) begin : g_riseSync
      always_ff @(posedge clk)
        if (srHit)            stored <= strobe.srFill;
        else if (strobe.load) stored <= lutOut;
    end else if (SR_ASYNC) begin : g_fallAsync
      always_ff @(negedge clk or posedge srHit)
        if (srHit)            stored <= strobe.srFill;
        else if (strobe.load) stored <= lutOut;
    end else begin : g_fallSync
      always_ff @(negedge clk)
        if (srHit)            stored <= strobe.srFill;
        else if (strobe.load) stored <= lutOut;
    end
  endgenerate

  assign regOut  = stored;
  assign cellOut = regSel ? stored : lutOut;
endmodule

// File: rtl/lcc_datapath.sv
module lcc_datapath
  import lcc_pkg::*;
#(
  parameter int CELLS         = 8,
  parameter int LUT_K         = 4,
  parameter bit ACTIVE_RISING = 1'b1,
  parameter bit SR_ASYNC      = 1'b0,
  localparam int TABLE        = 1 << LUT_K
) (
  input  logic                   clk,
  input  cellStrobe_t            strobe,
  input  logic                   carryIn,
  input  logic [CELLS*LUT_K-1:0] lutIn,
  input  logic [CELLS*TABLE-1:0] truthTab,
  input  logic [CELLS-1:0]       regSel,
  output logic [CELLS-1:0]       lutOut,
  output logic [CELLS-1:0]       regOut,
  output logic [CELLS-1:0]       cellOut,
  output logic [CELLS-1:0]       carryChain
);
  logic [CELLS:0] carryLink;

  assign carryLink[0] = carryIn;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    lcc_cell #(
      .LUT_K        (LUT_K),
      .ACTIVE_RISING(ACTIVE_RISING),
      .SR_ASYNC     (SR_ASYNC)
    ) u_cell (
      .clk     (clk),
      .strobe  (strobe),
      .lutIn   (lutIn[c*LUT_K +: LUT_K]),
      .truthTab(truthTab[c*TABLE +: TABLE]),
      .carryIn (carryLink[c]),
      .regSel  (regSel[c]),
      .lutOut  (lutOut[c]),
      .regOut  (regOut[c]),
      .cellOut (cellOut[c]),
      .carryOut(carryLink[c+1])
    );
  end

  assign carryChain = carryLink[CELLS:1];
endmodule

// File: rtl/lcc_top.sv
module lcc_top
  import lcc_pkg::*;
#(
  parameter int      CELLS         = 8,
  parameter int      LUT_K         = 4,
  parameter bit      ACTIVE_RISING = 1'b1,
  parameter bit      HAS_ENABLE    = 1'b1,
  parameter srKind_e SR_KIND       = SR_RESET,
  parameter bit      SR_ASYNC      = 1'b0,
  localparam int     TABLE         = 1 << LUT_K
) (
  input  logic                   clk,
  input  logic                   clkEn,
  input  logic                   srIn,
  input  logic                   carryIn,
  input  logic [CELLS*LUT_K-1:0] lutIn,
  input  logic [CELLS*TABLE-1:0] truthTab,
  input  logic [CELLS-1:0]       regSel,
  output logic [CELLS-1:0]       lutOut,
  output logic [CELLS-1:0]       regOut,
  output logic [CELLS-1:0]       cellOut,
  output logic [CELLS-1:0]       carryChain,
  output logic                   carryOut
);
  cellStrobe_t strobe;

  lcc_ctrl #(
    .HAS_ENABLE(HAS_ENABLE),
    .SR_KIND   (SR_KIND)
  ) u_ctrl (
    .clkEn (clkEn),
    .srIn  (srIn),
    .strobe(strobe)
  );

  lcc_datapath #(
    .CELLS        (CELLS),
    .LUT_K        (LUT_K),
    .ACTIVE_RISING(ACTIVE_RISING),
    .SR_ASYNC     (SR_ASYNC)
  ) u_datapath (
    .clk       (clk),
    .strobe    (strobe),
    .carryIn   (carryIn),
    .lutIn     (lutIn),
    .truthTab  (truthTab),
    .regSel    (regSel),
    .lutOut    (lutOut),
    .regOut    (regOut),
    .cellOut   (cellOut),
    .carryChain(carryChain)
  );

  assign carryOut = carryChain[CELLS-1];
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker
  import lcc_pkg::*;
#(
  parameter int      CELLS         = 8,
  parameter int      LUT_K         = 4,
  parameter bit      ACTIVE_RISING = 1'b1,
  parameter bit      HAS_ENABLE    = 1'b1,
  parameter srKind_e SR_KIND       = SR_RESET,
  parameter bit      SR_ASYNC      = 1'b0
) (
  input logic                   clk,
  input logic                   clkEn,
  input logic                   srIn,
  input logic                   carryIn,
  input logic [CELLS*LUT_K-1:0] lutIn,
  input logic [CELLS-1:0]       lutOut,
  input logic [CELLS-1:0]       regOut,
  input logic [CELLS-1:0]       carryChain
);
  localparam bit SR_PRESENT = (SR_KIND != SR_NONE);
  localparam logic [CELLS-1:0] FILL = (SR_KIND == SR_SET) ? '1 : '0;

  logic srGate;
  logic loadOk;
  assign srGate = SR_PRESENT && srIn;
  assign loadOk = HAS_ENABLE ? clkEn : 1'b1;

  for (genvar c = 0; c < CELLS; c++) begin : g_carry
    logic below;
    int   votes;
    if (c == 0) begin : g_bottom
      assign below = carryIn;
    end else begin : g_upper
      assign below = carryChain[c-1];
    end
    assign votes = int'(lutIn[c*LUT_K]) + int'(lutIn[c*LUT_K+1]) + int'(below);
    AST_CARRY_MAJORITY: assert property (@(posedge clk) disable iff (srGate)
      carryChain[c] == (votes >= 2)); // R2
  end

  if (ACTIVE_RISING) begin : g_rise
    AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (srGate)
      loadOk |=> regOut == $past(lutOut)); // R4
    if (HAS_ENABLE) begin : g_hold
      AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (srGate)
        !clkEn |=> $stable(regOut)); // R5
    end
    if (SR_PRESENT && !SR_ASYNC) begin : g_sync
      AST_SYNC_FORCE: assert property (@(posedge clk) disable iff (1'b0)
        srIn |=> regOut == FILL); // R6
    end
  end else begin : g_fall
    AST_CAPTURE_FALL: assert property (@(negedge clk) disable iff (srGate)
      loadOk |=> regOut == $past(lutOut)); // R4
    if (SR_PRESENT && !SR_ASYNC) begin : g_sync
      AST_SYNC_FORCE_FALL: assert property (@(negedge clk) disable iff (1'b0)
        srIn |=> regOut == FILL); // R6
    end
  end

  if (SR_PRESENT && SR_ASYNC) begin : g_async
    AST_ASYNC_FORCE: assert property (@(posedge clk) disable iff (1'b0)
      srIn |-> regOut == FILL); // R7
  end
endmodule

bind lcc_top lcc_checker #(
  .CELLS        (CELLS),
  .LUT_K        (LUT_K),
  .ACTIVE_RISING(ACTIVE_RISING),
  .HAS_ENABLE   (HAS_ENABLE),
  .SR_KIND      (SR_KIND),
  .SR_ASYNC     (SR_ASYNC)
) u_lcc_checker (
  .clk       (clk),
  .clkEn     (clkEn),
  .srIn      (srIn),
  .carryIn   (carryIn),
  .lutIn     (lutIn),
  .lutOut    (lutOut),
  .regOut    (regOut),
  .carryChain(carryChain)
);

// File: tb/test_lcc_top.sv
`timescale 1ns/1ps
module test_lcc_top;
  import lcc_pkg::*;

  logic         clk = 1'b0;
  logic         clkEn, srA, srB, carryIn;
  logic [31:0]  lutIn;
  logic [127:0] truthTab;
  logic [7:0]   regSel;
  logic [7:0]   lutOutA, regOutA, cellOutA, chainA;
  logic [7:0]   lutOutB, regOutB, cellOutB, chainB;
  logic         carryOutA, carryOutB;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [7:0] qA = 8'h00;
  logic [7:0] qB = 8'h00;
  string tagA = "R8";
  string tagB = "R8";

  always #2.5 clk = ~clk;

  lcc_top #(.ACTIVE_RISING(1'b1), .HAS_ENABLE(1'b1), .SR_KIND(SR_RESET), .SR_ASYNC(1'b0)) i_lcc_top (
    .clk(clk), .clkEn(clkEn), .srIn(srA), .carryIn(carryIn), .lutIn(lutIn),
    .truthTab(truthTab), .regSel(regSel), .lutOut(lutOutA), .regOut(regOutA),
    .cellOut(cellOutA), .carryChain(chainA), .carryOut(carryOutA));

  lcc_top #(.ACTIVE_RISING(1'b0), .HAS_ENABLE(1'b0), .SR_KIND(SR_SET), .SR_ASYNC(1'b1)) i_lcc_top_b (
    .clk(clk), .clkEn(clkEn), .srIn(srB), .carryIn(carryIn), .lutIn(lutIn),
    .truthTab(truthTab), .regSel(regSel), .lutOut(lutOutB), .regOut(regOutB),
    .cellOut(cellOutB), .carryChain(chainB), .carryOut(carryOutB));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("[TB] FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] lutRef();
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = truthTab[c*16 + int'(lutIn[c*4 +: 4])];
    return v;
  endfunction

  function automatic logic [7:0] carryRef();
    logic [7:0] v;
    logic cy = carryIn;
    for (int c = 0; c < 8; c++) begin
      v[c] = (int'(lutIn[c*4]) + int'(lutIn[c*4+1]) + int'(cy)) >= 2;
      cy = v[c];
    end
    return v;
  endfunction

  task automatic compareAll();
    logic [7:0] lv;
    logic [7:0] cv;
    lv = lutRef();
    cv = carryRef();
    check("R1 table bit select A", lutOutA, lv);
    check("R1 table bit select B", lutOutB, lv);
    check("R2 carry majority", chainA, cv);
    check("R3 carry chain top", {7'd0, carryOutA}, {7'd0, cv[7]});
    check("R3 carry chain B", chainB, cv);
    check({tagA, " stored value A"}, regOutA, qA);
    check({tagB, " stored value B"}, regOutB, qB);
    check("R9 output select A", cellOutA, (regSel & qA) | (~regSel & lv));
    check("R9 output select B", cellOutB, (regSel & qB) | (~regSel & lv));
  endtask

  task automatic step(input logic [31:0] li, input logic [127:0] tt, input logic [7:0] rs,
                      input logic en, input logic ra, input logic rb, input logic ci);
    logic [7:0] lv;
    @(posedge clk);
    #1.25;
    compareAll();
    lutIn = li; truthTab = tt; regSel = rs; clkEn = en; srA = ra; srB = rb; carryIn = ci;
    #0.3;
    if (ra) check("R6 sync reset waits for edge", regOutA, qA);
    if (rb) check("R7 async set acts at once", regOutB, 8'hFF);
    lv = lutRef();
    qA = ra ? 8'h00 : (en ? lv : qA);
    qB = rb ? 8'hFF : lv;
    tagA = ra ? "R6" : (en ? "R4" : "R5");
    tagB = rb ? "R7" : (en ? "R4" : "R5");
  endtask

  function automatic logic [127:0] tables(input int sel);
    logic [15:0] pool [4] = '{16'h8000, 16'h6996, 16'hFFFE, 16'hA5C3};
    logic [127:0] t;
    for (int c = 0; c < 8; c++) t[c*16 +: 16] = pool[(c + sel) % 4];
    return t;
  endfunction

  function automatic logic [31:0] sweep(input int k);
    logic [31:0] v;
    for (int c = 0; c < 8; c++) v[c*4 +: 4] = 4'((k + 3*c) % 16);
    return v;
  endfunction

  initial begin
    lutIn = 32'h0; truthTab = '0; regSel = 8'h00; clkEn = 1'b0;
    srA = 1'b0; srB = 1'b0; carryIn = 1'b0;
    #1;
    check("R8 initial zero A", regOutA, 8'h00);
    check("R8 initial zero B", regOutB, 8'h00);

    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 16; k++)
        step(sweep(k), tables(s), 8'h00, 1'b1, 1'b0, 1'b0, k[0]);

    for (int k = 0; k < 10; k++)
      step({8{4'b0001}}, tables(k), 8'hFF, 1'b1, 1'b0, 1'b0, k[0]);
    step({8{4'b0011}}, tables(1), 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
    step({8{4'b0000}}, tables(2), 8'hF0, 1'b1, 1'b0, 1'b0, 1'b1);

    step(sweep(5), tables(1), 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    step(sweep(9), tables(3), 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    step(sweep(2), 128'h0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    step(sweep(2), {128{1'b1}}, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
    step(sweep(7), {128{1'b1}}, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
    step(sweep(7), 128'h0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
    step(sweep(4), tables(0), 8'h55, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 200; k++)
      step($urandom, {$urandom, $urandom, $urandom, $urandom}, 8'($urandom),
           ($urandom % 3) != 0, ($urandom % 7) == 0, ($urandom % 9) == 0, 1'($urandom));

    step(sweep(0), tables(0), 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step(sweep(1), tables(1), 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("[TB] FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule